// File: doc/BRIEF.md
# Routed Vector Interrupt Controller

This block gathers 256 edge-triggered interrupt vectors and steers each of them to one or more of four cores. On each core it drives one of eight interrupt lines. A rising edge on a vector input latches a status bit. The status bit is qualified by a per-vector enable bit. Each vector has its own route byte: the low nibble is a core bitmap and the high nibble is a node number, which is stored but has no effect. A per-group line map byte, one for each group of 32 vectors, picks which of the eight lines on a core the group raises.

Software uses a 64-bit register port with byte strobes, and a 32-bit access simply drives four lanes. Every access must be aligned to 8 bytes. Each write strobe selects one byte lane, and byte k of the word at address A is byte address A+k. A core acknowledges interrupts by reading a status word and writing the same value back, because the status words are write-1-to-clear. To move a vector, software clears its enable bit, rewrites its route byte and then sets the enable bit again.

A vector with its bounce bit set does not go to its whole bitmap. Each new edge goes to a single core, taken in turn from the set bits of its bitmap.

Top module: `rvic`

## Requirements
- R1: Reset clears the status, enable, bounce, route and line map registers, so they read as zero and every output line is low. Reset also sets each vector's bounce pointer so that its first delivery goes to the lowest set core of its bitmap.
- R2: A rising edge on irq_in[v] sets status bit v one clock later. Status bit v is read at 0x1800 + 8*(v/64), bit v%64. A level that stays high does not set the bit again once it has been cleared.
- R3: A write to a status word clears every bit written as 1 within a strobed byte lane and leaves all other bits unchanged. When a new edge and a clear hit the same bit in the same cycle, the bit stays set.
- R4: Enable bit v is at 0x1600 + 8*(v/64), bit v%64, and bounce bit v is at 0x1680 + 8*(v/64), bit v%64. Both are readable and writable, and only strobed byte lanes change.
- R5: The route byte of vector v is at 0x1C00 + v, with bits [3:0] as the core bitmap and bits [7:4] as the node number. A write changes only the strobed bytes. The node number reads back but has no effect on any output.
- R6: The line map byte of group g (vectors 32g to 32g+31) is at 0x14C0 + g. Bit n of that byte routes the group to line n of a core.
- R7: Output irq_line[8c+n] is high when some vector has status set, enable set, delivery to core c and bit n set in its group's line map. A vector with its bounce bit clear is delivered to every core in its bitmap.
- R8: A vector whose enable bit is low never raises an output line. A pending vector that becomes enabled raises its lines in the cycle after the write.
- R9: A vector with its bounce bit set is delivered to one core only, the one its bounce pointer selects. On each new edge the pointer moves to the next set bit of the bitmap in cyclic order. With bitmap 4'b1101 the successive edges go to cores 0, 2, 3 and then 0 again.
- R10: Read data appears one clock after the address is presented. Unmapped or misaligned addresses read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NVEC | Edge-triggered vector inputs |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte address, 8-byte aligned |
| wdata | input | 64 | Write data |
| wstrb | input | 8 | Byte lane strobes for writes |
| rdata | output | 64 | Read data for the previous cycle's address |
| irq_line | output | 32 | Interrupt lines, index 8*core + line |

## Verification
The bound checker watches several behaviours on every cycle. No output line rises unless some vector is both pending and enabled. Every input edge appears in status on the next cycle. A full write-back of all ones to status word 0 empties it when no edge arrives in the same cycle. Unmapped reads return zero, and the enable and bounce registers hold steady while no write happens. Other behaviours can only be shown by the bench's scenarios, because their expected values depend on a configured route. These are strobe-merged register contents, the exact line pattern a route byte and line map produce, the node nibble having no effect, the set-wins collision and the round-robin order of bounce delivery.

// File: rtl/rvic.sv
module rvic #(
  parameter int NVEC = 256,
  parameter int AW   = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NVEC-1:0] irq_in,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [63:0]     wdata,
  input  logic [7:0]      wstrb,
  output logic [63:0]     rdata,
  output logic [31:0]     irq_line
);
  localparam int NW  = NVEC / 64;
  localparam int NG  = NVEC / 32;
  localparam int NRW = NVEC / 8;
  localparam int NC  = 4;
  localparam int NL  = 8;
  localparam logic [AW-4:0] LM_B = (AW-3)'('h298);
  localparam logic [AW-4:0] EN_B = (AW-3)'('h2C0);
  localparam logic [AW-4:0] BN_B = (AW-3)'('h2D0);
  localparam logic [AW-4:0] ST_B = (AW-3)'('h300);
  localparam logic [AW-4:0] RT_B = (AW-3)'('h380);

  logic [NVEC-1:0]   stat, en, bnc, prev, edg, clr;
  logic [8*NVEC-1:0] route;
  logic [8*NG-1:0]   lmap;
  logic [2*NVEC-1:0] sel;
  logic [NC*NG-1:0]  hit;
  logic [63:0]       bm, rd_n;
  logic [AW-4:0]     wi;
  logic              acc, wr;

  assign wi  = addr[AW-1:3];
  assign acc = (addr[2:0] == 3'd0);
  assign wr  = wr_en & acc;
  assign edg = irq_in & ~prev;

  always_comb
    for (int b = 0; b < 8; b++) bm[b*8 +: 8] = {8{wstrb[b]}};

  always_comb begin
    clr = '0;
    for (int w = 0; w < NW; w++)
      if (wr && wi == ST_B + (AW-3)'(w)) clr[w*64 +: 64] = wdata & bm;
  end

  function automatic logic [1:0] nxt(input logic [1:0] cur, input logic [3:0] m);
    logic [1:0] r, idx;
    logic f;
    r = cur;
    f = 1'b0;
    for (int k = 1; k <= NC; k++) begin
      idx = cur + 2'(k);
      if (!f && m[idx]) begin
        r = idx;
        f = 1'b1;
      end
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stat  <= '0;
      en    <= '0;
      bnc   <= '0;
      prev  <= '0;
      route <= '0;
      lmap  <= '0;
      sel   <= '1;
    end else begin
      prev <= irq_in;
      stat <= (stat & ~clr) | edg;
      if (wr) begin
        for (int w = 0; w < NW; w++) begin
          if (wi == EN_B + (AW-3)'(w)) en[w*64 +: 64]  <= (en[w*64 +: 64] & ~bm) | (wdata & bm);
          if (wi == BN_B + (AW-3)'(w)) bnc[w*64 +: 64] <= (bnc[w*64 +: 64] & ~bm) | (wdata & bm);
        end
        for (int w = 0; w < NRW; w++)
          if (wi == RT_B + (AW-3)'(w))
            route[w*64 +: 64] <= (route[w*64 +: 64] & ~bm) | (wdata & bm);
        for (int k = 0; k < NG; k++)
          if (wi == LM_B + (AW-3)'(k / 8) && wstrb[k % 8])
            lmap[k*8 +: 8] <= wdata[(k % 8)*8 +: 8];
      end
      for (int v = 0; v < NVEC; v++)
        if (edg[v] && bnc[v]) sel[v*2 +: 2] <= nxt(sel[v*2 +: 2], route[v*8 +: 4]);
    end

  always_comb begin
    rd_n = '0;
    if (acc) begin
      for (int w = 0; w < NW; w++) begin
        if (wi == EN_B + (AW-3)'(w)) rd_n = en[w*64 +: 64];
        if (wi == BN_B + (AW-3)'(w)) rd_n = bnc[w*64 +: 64];
        if (wi == ST_B + (AW-3)'(w)) rd_n = stat[w*64 +: 64];
      end
      for (int w = 0; w < NRW; w++)
        if (wi == RT_B + (AW-3)'(w)) rd_n = route[w*64 +: 64];
      for (int k = 0; k < NG; k++)
        if (wi == LM_B + (AW-3)'(k / 8)) rd_n[(k % 8)*8 +: 8] = lmap[k*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_n;

  always_comb begin
    logic [3:0] tgt;
    hit = '0;
    for (int v = 0; v < NVEC; v++) begin
      tgt = bnc[v] ? ((4'b0001 << sel[v*2 +: 2]) & route[v*8 +: 4]) : route[v*8 +: 4];
      for (int c = 0; c < NC; c++)
        if (stat[v] && en[v] && tgt[c]) hit[c*NG + v/32] = 1'b1;
    end
  end

  always_comb begin
    irq_line = '0;
    for (int c = 0; c < NC; c++)
      for (int n = 0; n < NL; n++)
        for (int g = 0; g < NG; g++)
          if (hit[c*NG + g] && lmap[g*8 + n]) irq_line[c*NL + n] = 1'b1;
  end
endmodule

// File: rtl/rvic_chk.sv
module rvic_chk #(
  parameter int NVEC = 256,
  parameter int AW   = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NVEC-1:0] irq_in,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [63:0]     wdata,
  input logic [7:0]      wstrb,
  input logic [63:0]     rdata,
  input logic [31:0]     irq_line,
  input logic [NVEC-1:0] stat,
  input logic [NVEC-1:0] en,
  input logic [NVEC-1:0] bnc
);
  logic [NVEC-1:0] prv, edg_q;
  logic            unm_q, clr_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prv   <= '0;
      edg_q <= '0;
      unm_q <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      prv   <= irq_in;
      edg_q <= irq_in & ~prv;
      unm_q <= (addr >= AW'('h1D00));
      clr_q <= wr_en && addr == AW'('h1800) && wstrb == 8'hFF && wdata == '1
               && (irq_in[63:0] & ~prv[63:0]) == 64'd0;
    end

  assert_no_line_unless_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_line != 32'd0) |-> ((stat & en) != '0));

  assert_edge_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edg_q != '0) |-> ((stat & edg_q) == edg_q));

  assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    unm_q |-> (rdata == 64'd0));

  assert_full_writeback_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> (stat[63:0] == 64'd0));

  assert_cfg_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(en) && $stable(bnc)));
endmodule

bind rvic rvic_chk #(.NVEC(NVEC), .AW(AW)) u_chk (.*);

// File: tb/rvic_tb.sv
module rvic_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [255:0] irq = '0;
  logic         wr_en = 1'b0;
  logic [12:0]  addr = '0;
  logic [63:0]  wdata = '0;
  logic [7:0]   wstrb = '0;
  logic [63:0]  rdata;
  logic [31:0]  irq_line;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  rvic u_dut (.clk(clk), .rst_n(rst_n), .irq_in(irq), .wr_en(wr_en), .addr(addr),
              .wdata(wdata), .wstrb(wstrb), .rdata(rdata), .irq_line(irq_line));

  // {vector, route byte, line map byte, expected irq_line}
  localparam logic [55:0] TBL [5] = '{
    {8'd5,   8'h01, 8'h02, 32'h0000_0002},
    {8'd40,  8'h0A, 8'h81, 32'h8100_8100},
    {8'd255, 8'hF4, 8'h10, 32'h0010_0000},
    {8'd100, 8'h0F, 8'h01, 32'h0101_0101},
    {8'd64,  8'h00, 8'hFF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [63:0] d, input logic [7:0] s);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; wstrb = s;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wstrb = '0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [63:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
    addr = '0;
  endtask

  task automatic pulse(input int v);
    @(negedge clk);
    irq[v] = 1'b1;
    @(negedge clk);
    irq[v] = 1'b0;
  endtask

  task automatic clear_all();
    for (int w = 0; w < 4; w++) begin
      wr(13'h1600 + 13'(8*w), 64'd0, 8'hFF);
      wr(13'h1680 + 13'(8*w), 64'd0, 8'hFF);
      wr(13'h1800 + 13'(8*w), '1, 8'hFF);
    end
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(13'h1600, d); chk("R1 enable reset", d, 0);
    rd(13'h1680, d); chk("R1 bounce reset", d, 0);
    rd(13'h1800, d); chk("R1 status reset", d, 0);
    rd(13'h1C00, d); chk("R1 route reset", d, 0);
    rd(13'h14C0, d); chk("R1 line map reset", d, 0);
    chk("R1 lines reset", 64'(irq_line), 0);

    wr(13'h1000, '1, 8'hFF);
    rd(13'h1000, d); chk("R10 unmapped read", d, 0);
    rd(13'h1D00, d); chk("R10 past route read", d, 0);
    rd(13'h14C8, d); chk("R10 beyond line map read", d, 0);
    wr(13'h1604, '1, 8'hFF);
    rd(13'h1600, d); chk("R10 misaligned write ignored", d, 0);

    wr(13'h1608, 64'hAAAA_AAAA_5555_5555, 8'h30);
    rd(13'h1608, d); chk("R4 enable strobe merge", d, 64'h0000_AAAA_0000_0000);
    wr(13'h1698, 64'hAAAA_AAAA_5555_5555, 8'h0F);
    rd(13'h1698, d); chk("R4 bounce strobe merge", d, 64'h0000_0000_5555_5555);
    clear_all();

    wr(13'h1C00, 64'h8877_6655_4433_2211, 8'hFF);
    wr(13'h1C00, 64'h0000_0000_00AB_0000, 8'h04);
    rd(13'h1C00, d); chk("R5 route byte write", d, 64'h8877_6655_44AB_2211);
    wr(13'h1C00, 64'd0, 8'hFF);

    pulse(3);
    pulse(70);
    rd(13'h1800, d); chk("R2 status vector 3", d, 64'h8);
    rd(13'h1808, d); chk("R2 status vector 70", d, 64'h40);
    wr(13'h1800, 64'h8, 8'h00);
    rd(13'h1800, d); chk("R3 unstrobed clear ignored", d, 64'h8);
    wr(13'h1800, 64'h8, 8'h01);
    rd(13'h1800, d); chk("R3 write one clears", d, 0);
    rd(13'h1808, d); chk("R3 other word untouched", d, 64'h40);
    @(negedge clk);
    irq[3] = 1'b1; wr_en = 1'b1; addr = 13'h1800; wdata = 64'h8; wstrb = 8'h01;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wstrb = '0;
    rd(13'h1800, d); chk("R3 set wins over clear", d, 64'h8);
    wr(13'h1800, 64'h8, 8'h01);
    rd(13'h1800, d); chk("R2 held level does not re-set", d, 0);
    irq[3] = 1'b0;
    clear_all();

    wr(13'h14C0, 64'h01, 8'h01);
    wr(13'h1C00, 64'h01 << 40, 8'h20);
    pulse(5);
    chk("R8 disabled vector silent", 64'(irq_line), 0);
    wr(13'h1600, 64'h1 << 5, 8'h01);
    chk("R8 enable raises line", 64'(irq_line), 64'h1);
    wr(13'h1600, 64'd0, 8'h01);
    chk("R8 disable drops line", 64'(irq_line), 0);
    clear_all();

    wr(13'h1C08, 64'h0D << 16, 8'h04);
    wr(13'h1680, 64'h1 << 10, 8'h02);
    wr(13'h1600, 64'h1 << 10, 8'h02);
    pulse(10);
    chk("R9 bounce first core0", 64'(irq_line), 64'h1);
    wr(13'h1800, 64'h1 << 10, 8'h02);
    chk("R3 acknowledge drops line", 64'(irq_line), 0);
    pulse(10);
    chk("R9 bounce second core2", 64'(irq_line), 64'h0001_0000);
    wr(13'h1800, 64'h1 << 10, 8'h02);
    pulse(10);
    chk("R9 bounce third core3", 64'(irq_line), 64'h0100_0000);
    wr(13'h1800, 64'h1 << 10, 8'h02);
    pulse(10);
    chk("R9 bounce wraps core0", 64'(irq_line), 64'h1);
    clear_all();

    for (int i = 0; i < 5; i++) begin
      logic [55:0] e;
      int v;
      e = TBL[i];
      v = int'(e[55:48]);
      wr(13'h14C0, 64'(e[39:32]) << (8 * (v / 32)), 8'hFF);
      wr(13'h1C00 + 13'(v & 248), 64'(e[47:40]) << (8 * (v % 8)), 8'h01 << (v % 8));
      wr(13'h1600 + 13'(8 * (v / 64)), 64'h1 << (v % 64), 8'h01 << ((v % 64) / 8));
      pulse(v);
      chk($sformatf("R7 R6 R5 table entry %0d", i), 64'(irq_line), 64'(e[31:0]));
      clear_all();
      chk($sformatf("R7 lines idle after entry %0d", i), 64'(irq_line), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule